// File: doc/BRIEF.md
# Oversampled Bit Clock Recovery

This block takes a single-bit demodulated FSK stream and turns it into retimed data bits, each marked by a one-cycle strobe. The strobe is meant to drive the write side of a receive FIFO. The stream is sampled only in cycles where `tick_en` is high. The enable must run at the oversampling ratio times the nominal bit rate, which is 29 by default, so one bit spans 29 ticks.

Each sample first passes through a short majority-vote filter. A phase counter then runs from 0 to 28 and marks the mid-bit sampling point. Every transition of the filtered stream gives a phase error, which pulls the counter toward the point where edges are expected. The correction is either aggressive (fast tracking) or at most one tick per edge (slow tracking). A lock monitor watches the run of recent errors. In automatic mode the block acquires with fast tracking and switches to slow tracking while lock is held.

Top module: `bitclk_recover`

## Requirements
- R1: A synchronous active-low reset clears the phase counter, `data_valid` and `locked`. With `mode` in automatic, `trk_fast` reads 1 straight after reset.
- R2: Filtering is a majority vote over the current sample and the two previous ones. A single-sample flip on an otherwise steady line does not change the recovered data and produces no edge.
- R3: `data_valid` pulses for one clock after the tick on which the counter equals 14. `data_out` then carries the filtered bit. With a zero rate offset and a settled loop, strobes are exactly 29 ticks apart.
- R4: The phase error of an edge is c when the counter c is at most 14, and c-29 otherwise. In fast tracking each edge moves the counter toward 0 by the error magnitude halved and rounded up. From a 10-tick initial error, lock is held by the 12th edge.
- R5: In slow tracking each edge moves the counter toward 0 by at most one tick. From the same 10-tick start, the block is not locked after 12 edges and is locked after 16.
- R6: Lock is set after 8 consecutive edges with an error magnitude of 3 or less. An edge with a magnitude of 4 to 7 restarts both the good and the bad edge runs.
- R7: `mode` 2'b00 is fast, 2'b01 is slow, and 2'b10 and 2'b11 are automatic. In automatic mode `trk_fast` is 1 while unlocked and 0 while locked.
- R8: Lock clears after 4 consecutive edges with an error magnitude above 7; three such edges are not enough. Automatic mode then returns to fast tracking.
- R9: At a ±2% rate offset with isolated single-sample glitches, the strobed bits match the transmitted bits, with about one strobe per bit.
- R10: In a cycle with `tick_en` low, no strobe is produced and the phase counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Sample enable at 29 times the bit rate |
| raw_bit | input | 1 | Demodulated data bit |
| mode | input | 2 | Tracking mode: 00 fast, 01 slow, 1x automatic |
| data_out | output | 1 | Retimed data bit |
| data_valid | output | 1 | One-cycle strobe qualifying `data_out` |
| locked | output | 1 | Lock flag |
| trk_fast | output | 1 | 1 while fast tracking is in use |

## Verification
The bench starts fast, slow and automatic acquisitions from the same 10-tick phase error and samples `locked` at edges 12 and 16. A wrong step size or wrong rounding moves lock to a different edge, so the check at that edge reports it. A 14-tick phase jump after lock checks that three bad edges keep lock and the fourth clears it. An off-by-one bad-edge count, or an automatic mode that stays slow, fails there. Long streams at +2% and -2% with glitches, including a random-data run in fast mode, expose a filter that passes glitches or a strobe that drifts off mid-bit as data mismatches or missing strobes.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
    // Tracking mode codes seen on the mode input
    typedef enum logic [1:0] {
        TRK_FAST     = 2'b00,
        TRK_SLOW     = 2'b01,
        TRK_AUTO     = 2'b10,
        TRK_AUTO_ALT = 2'b11
    } trk_mode_e;

    localparam int unsigned DEF_OSR = 29;
endpackage

// File: rtl/bcr_vote_filter.sv
// Majority-vote input filter.
// Keeps TAPS-1 past samples and votes over them and the current sample on
// every tick. The registered result lags the line by one tick.
// Assumes TAPS is odd and at least 3.
module bcr_vote_filter #(
    parameter int TAPS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic raw_bit,
    output logic filt_bit
);
    localparam int HIST = TAPS - 1;
    localparam int NEED = TAPS / 2 + 1;

    logic [HIST-1:0] hist_q;
    logic [TAPS-1:0] win_w;

    assign win_w = {hist_q, raw_bit};

    // Shift the sample window and register the vote on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q   <= '0;
            filt_bit <= 1'b0;
        end else if (tick_en) begin
            hist_q   <= win_w[HIST-1:0];
            filt_bit <= ($countones(win_w) >= NEED);
        end
    end
endmodule

// File: rtl/bcr_phase_track.sv
// Phase counter, edge detector, phase corrector and mid-bit strobe.
// The counter runs 0..OSR-1 once per tick. An edge in the filtered stream
// is expected at count 0. When an edge arrives, the counter moves toward
// 0 by a step that depends on fast_sel. The bit is strobed at count OSR/2.
// Assumes the filtered input only changes on ticks.
module bcr_phase_track #(
    parameter int OSR = 29,
    parameter int PW  = $clog2(OSR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          filt_bit,
    input  logic          fast_sel,
    output logic          edge_seen,
    output logic [PW-1:0] err_mag,
    output logic [PW-1:0] phase,
    output logic          data_out,
    output logic          data_valid
);
    localparam int              HALF = OSR / 2;
    localparam logic [PW-1:0]   LAST = PW'(OSR - 1);
    localparam logic [PW-1:0]   MID  = PW'(HALF);
    localparam logic [PW:0]     OSRW = (PW+1)'(OSR);

    logic [PW-1:0] ph_q;
    logic          prev_q;
    logic          late_w;
    logic [PW-1:0] base_w;
    logic [PW-1:0] step_w;
    logic [PW:0]   sum_w;
    logic [PW:0]   wrap_w;
    logic [PW-1:0] next_w;

    assign phase     = ph_q;
    assign edge_seen = tick_en && (filt_bit != prev_q);

    // Signed phase error split into direction and magnitude
    always_comb begin
        late_w  = (ph_q <= MID);
        err_mag = late_w ? ph_q : (PW'(OSR) - ph_q);
    end

    // Correction step: half the magnitude rounded up, or a single tick
    always_comb begin
        if (fast_sel) begin
            step_w = PW'(({1'b0, err_mag} + 1'b1) >> 1);
        end else begin
            step_w = (err_mag != '0) ? PW'(1) : '0;
        end
    end

    // Free-running successor and corrected successor with wrap-around
    always_comb begin
        base_w = (ph_q == LAST) ? '0 : (ph_q + 1'b1);
        if (late_w) begin
            sum_w = {1'b0, base_w} + OSRW - {1'b0, step_w};
        end else begin
            sum_w = {1'b0, base_w} + {1'b0, step_w};
        end
        wrap_w = (sum_w >= OSRW) ? (sum_w - OSRW) : sum_w;
        next_w = edge_seen ? wrap_w[PW-1:0] : base_w;
    end

    // Advance the counter and remember the last filtered bit on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= '0;
            prev_q <= 1'b0;
        end else if (tick_en) begin
            ph_q   <= next_w;
            prev_q <= filt_bit;
        end
    end

    // Capture the bit and raise a one-cycle strobe at mid-bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_valid <= 1'b0;
            data_out   <= 1'b0;
        end else begin
            data_valid <= 1'b0;
            if (tick_en && (ph_q == MID)) begin
                data_valid <= 1'b1;
                data_out   <= filt_bit;
            end
        end
    end
endmodule

// File: rtl/bcr_lock_mon.sv
// Lock monitor.
// Counts consecutive in-window edges to set lock and consecutive
// far-out edges to clear it. Any edge between the two windows restarts
// both runs. Both counters saturate.
// Assumes LOCK_WIN < UNLOCK_WIN.
module bcr_lock_mon #(
    parameter int PW           = 5,
    parameter int LOCK_WIN     = 3,
    parameter int UNLOCK_WIN   = 7,
    parameter int LOCK_EDGES   = 8,
    parameter int UNLOCK_EDGES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          edge_seen,
    input  logic [PW-1:0] err_mag,
    output logic          locked
);
    localparam int GW = $clog2(LOCK_EDGES + 1);
    localparam int BW = $clog2(UNLOCK_EDGES + 1);
    localparam logic [GW-1:0] GMAX = GW'(LOCK_EDGES);
    localparam logic [BW-1:0] BMAX = BW'(UNLOCK_EDGES);

    logic [GW-1:0] good_q, good_nx;
    logic [BW-1:0] bad_q,  bad_nx;
    logic          in_win, out_win;

    assign in_win  = (err_mag <= PW'(LOCK_WIN));
    assign out_win = (err_mag >  PW'(UNLOCK_WIN));

    // Saturating increments of both runs
    always_comb begin
        good_nx = (good_q == GMAX) ? good_q : (good_q + 1'b1);
        bad_nx  = (bad_q  == BMAX) ? bad_q  : (bad_q  + 1'b1);
    end

    // Update the runs and the lock flag on every detected edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_q <= '0;
            bad_q  <= '0;
            locked <= 1'b0;
        end else if (edge_seen) begin
            if (in_win) begin
                good_q <= good_nx;
                bad_q  <= '0;
                if (good_nx == GMAX) locked <= 1'b1;
            end else if (out_win) begin
                bad_q  <= bad_nx;
                good_q <= '0;
                if (bad_nx == BMAX) locked <= 1'b0;
            end else begin
                good_q <= '0;
                bad_q  <= '0;
            end
        end
    end
endmodule

// File: rtl/bitclk_recover.sv
// Oversampled bit clock recovery, top level.
// Chains the vote filter, the phase tracker and the lock monitor, and
// picks fast or slow correction from the mode input and the lock flag.
// Assumes tick_en runs at OSR times the bit rate.
module bitclk_recover
    import bcr_pkg::*;
#(
    parameter int OSR          = DEF_OSR,
    parameter int FILT_TAPS    = 3,
    parameter int LOCK_WIN     = 3,
    parameter int UNLOCK_WIN   = 7,
    parameter int LOCK_EDGES   = 8,
    parameter int UNLOCK_EDGES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       raw_bit,
    input  logic [1:0] mode,
    output logic       data_out,
    output logic       data_valid,
    output logic       locked,
    output logic       trk_fast
);
    localparam int PW = $clog2(OSR);

    logic          filt_w;
    logic          edge_w;
    logic [PW-1:0] err_w;
    logic [PW-1:0] phase_q;
    trk_mode_e     mode_e;

    assign mode_e = trk_mode_e'(mode);

    // Fast correction in fast mode, or in automatic mode while unlocked
    always_comb begin
        case (mode_e)
            TRK_FAST: trk_fast = 1'b1;
            TRK_SLOW: trk_fast = 1'b0;
            default:  trk_fast = !locked;
        endcase
    end

    bcr_vote_filter #(
        .TAPS (FILT_TAPS)
    ) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .raw_bit  (raw_bit),
        .filt_bit (filt_w)
    );

    bcr_phase_track #(
        .OSR (OSR),
        .PW  (PW)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .filt_bit   (filt_w),
        .fast_sel   (trk_fast),
        .edge_seen  (edge_w),
        .err_mag    (err_w),
        .phase      (phase_q),
        .data_out   (data_out),
        .data_valid (data_valid)
    );

    bcr_lock_mon #(
        .PW           (PW),
        .LOCK_WIN     (LOCK_WIN),
        .UNLOCK_WIN   (UNLOCK_WIN),
        .LOCK_EDGES   (LOCK_EDGES),
        .UNLOCK_EDGES (UNLOCK_EDGES)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_seen (edge_w),
        .err_mag   (err_w),
        .locked    (locked)
    );
endmodule

// File: rtl/bcr_checker.sv
// Property checker for bitclk_recover, attached by bind below.
module bcr_checker #(
    parameter int OSR = 29
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tick_en,
    input logic [1:0]              mode,
    input logic                    data_valid,
    input logic                    locked,
    input logic                    trk_fast,
    input logic [$clog2(OSR)-1:0]  phase
);
    localparam int PW = $clog2(OSR);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!locked && !data_valid));

    assert_strobe_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> $past(tick_en));

    assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phase < PW'(OSR));

    assert_fast_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> trk_fast);

    assert_slow_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |-> !trk_fast);

    assert_lock_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(tick_en));

    assert_auto_locked_slow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && locked) |-> !trk_fast);

    assert_auto_unlocked_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && !locked) |-> trk_fast);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick_en)) |-> ($stable(phase) && $stable(locked)));
endmodule

bind bitclk_recover bcr_checker #(.OSR(OSR)) u_bcr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .mode       (mode),
    .data_valid (data_valid),
    .locked     (locked),
    .trk_fast   (trk_fast),
    .phase      (phase_q)
);

// File: tb/tb_bitclk_recover.sv
module tb_bitclk_recover;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       raw_bit = 1'b0;
    logic [1:0] mode = 2'b10;
    logic       data_out, data_valid, locked, trk_fast;

    int n_chk = 0;
    int n_bad = 0;
    int tick_num = 0;
    int last_v = -1;
    int valid_cnt = 0;
    int ones_cnt = 0;
    int spacing_bad = 0;
    int compared = 0;
    int mism = 0;
    bit spacing_on = 0;
    bit cmp_on = 0;
    logic [7:0] hist = '0;

    bitclk_recover dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .raw_bit(raw_bit),
        .mode(mode), .data_out(data_out), .data_valid(data_valid),
        .locked(locked), .trk_fast(trk_fast)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // One sample tick spread over two clocks; outputs sampled after it
    task automatic do_tick(input logic clean, input logic v);
        @(negedge clk);
        tick_en = 1'b1;
        raw_bit = v;
        @(negedge clk);
        tick_en = 1'b0;
        hist = {hist[6:0], clean};
        if (data_valid) begin
            valid_cnt++;
            if (data_out) ones_cnt++;
            if (spacing_on && last_v >= 0 && (tick_num - last_v) != 29) spacing_bad++;
            last_v = tick_num;
            if (cmp_on) begin
                compared++;
                if (data_out != hist[2]) mism++;
            end
        end
        tick_num++;
    endtask

    task automatic send_bit(input logic v, input int len);
        for (int k = 0; k < len; k++) do_tick(v, v);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick_num = 0;
        last_v = -1;
        valid_cnt = 0;
        ones_cnt = 0;
        compared = 0;
        mism = 0;
        cmp_on = 0;
        spacing_on = 0;
        spacing_bad = 0;
    endtask

    task automatic t_reset();
        mode = 2'b10;
        do_reset();
        @(negedge clk);
        check("R1", "locked after reset", int'(locked), 0);
        check("R1", "data_valid after reset", int'(data_valid), 0);
        check("R1", "trk_fast after reset (auto)", int'(trk_fast), 1);
    endtask

    task automatic t_filter();
        mode = 2'b10;
        do_reset();
        for (int t = 0; t < 290; t++) do_tick(1'b0, (t % 10) == 5);
        check("R2", "ones recovered from glitched zero line", ones_cnt, 0);
        check("R3", "strobes over 290 idle-line ticks", valid_cnt, 10);
        check("R2", "no lock from glitches", int'(locked), 0);
    endtask

    task automatic t_idle();
        int seen = 0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (data_valid) seen++;
        end
        check("R10", "strobes with tick_en low", seen, 0);
    endtask

    // Alternating bits, first edge lands at a 10-tick phase error
    task automatic t_acquire(input logic [1:0] md, input string req);
        mode = md;
        do_reset();
        send_bit(1'b0, 8);
        for (int n = 1; n <= 16; n++) begin
            send_bit(logic'(n % 2), 6);
            if (n == 12) check(req, "locked after 12 edges R6", int'(locked), (md == 2'b01) ? 0 : 1);
            if (n == 16 && md == 2'b01) check(req, "locked after 16 edges R6", int'(locked), 1);
            send_bit(logic'(n % 2), 23);
        end
    endtask

    task automatic t_auto_unlock();
        mode = 2'b10;
        do_reset();
        send_bit(1'b0, 8);
        for (int n = 1; n <= 21; n++) begin
            int len = (n == 17) ? 43 : 29;
            if (n == 12) begin spacing_on = 1; last_v = -1; end
            send_bit(logic'(n % 2), 6);
            if (n == 9)  check("R7", "trk_fast before lock", int'(trk_fast), 1);
            if (n == 12) begin
                check("R7", "locked in auto", int'(locked), 1);
                check("R7", "trk_fast after lock", int'(trk_fast), 0);
            end
            if (n == 20) check("R8", "lock kept after 3 far edges", int'(locked), 1);
            if (n == 21) begin
                check("R8", "lock cleared after 4 far edges", int'(locked), 0);
                check("R8", "auto back to fast", int'(trk_fast), 1);
            end
            send_bit(logic'(n % 2), len - 6);
            if (n == 16) begin
                spacing_on = 0;
                check("R3", "strobe spacing faults at zero offset", spacing_bad, 0);
            end
        end
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", "reset clears lock", int'(locked), 0);
        rst_n = 1'b1;
    endtask

    // Stream at an offset rate; paired=1 sends each data bit and its inverse
    task automatic t_stream(input logic [1:0] md, input int off, input bit paired,
                            input bit glitch, input bit want_lock);
        longint period;
        int b_prev;
        int win_bits;
        int d;
        logic [8:0] lf;
        logic cur;
        period = longint'(2900) * longint'(100 + off);
        b_prev = -1;
        win_bits = 0;
        lf = 9'h1A5;
        cur = 1'b0;
        mode = md;
        do_reset();
        for (int t = 0; t < 20000; t++) begin
            int b;
            b = int'((longint'(t) * 10000) / period);
            if (b >= 300) break;
            if (b != b_prev) begin
                if (!paired || (b % 2) == 0) begin
                    lf = {lf[7:0], lf[8] ^ lf[4]};
                    cur = lf[0];
                end else begin
                    cur = ~cur;
                end
                b_prev = b;
                if (cmp_on) win_bits++;
                if (b == 40) cmp_on = 1;
            end
            do_tick(cur, cur ^ (glitch && (t % 37) == 17));
        end
        cmp_on = 0;
        check("R9", $sformatf("data mismatches at %0d%% offset", off), mism, 0);
        d = compared - win_bits;
        check("R9", "strobe count minus bit count outside +-2", (d >= -2 && d <= 2) ? 0 : d, 0);
        if (want_lock) check("R9", "lock held on offset stream R6", int'(locked), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_filter();
        t_idle();
        t_acquire(2'b00, "R4");
        t_acquire(2'b01, "R5");
        t_auto_unlock();
        t_stream(2'b10,  2, 1'b1, 1'b1, 1'b1);
        t_stream(2'b11, -2, 1'b1, 1'b1, 1'b1);
        t_stream(2'b00, -2, 1'b0, 1'b1, 1'b0);
        t_stream(2'b00,  2, 1'b0, 1'b0, 1'b0);
        summary();
        $finish;
    end
endmodule